// File: doc/BRIEF.md
# Overcurrent Fault Monitor

This block watches a stream of unsigned current samples and raises an overcurrent indication whenever a sample exceeds a trip level. The trip level is picked by a 4-bit level code and set as a fraction of the converter's full-scale code. Full scale is code 511. Samples are 10 bits wide, so currents above full scale can still be compared against the upper trip levels.

It drives three outputs, all registered. The first is an instantaneous status that follows the most recent valid sample. The second is a sticky status that records any trip. The third is an active-low fault pin that mirrors the instantaneous status. The sticky status is cleared by a clear strobe, but only once the overcurrent has gone away. The level code sits in a small register that software writes through a write strobe, and it resets to the lowest trip level.

Top module: `oc_fault_monitor`

## Requirements
- R1: Level codes 0 to 15 select trip thresholds 256, 286, 322, 353, 388, 419, 450, 485, 516, 552, 583, 613, 649, 680, 715, 746. These are round(p*511/100) for p = 50, 56, 63, 69, 76, 82, 88, 95, 101, 108, 114, 120, 127, 133, 140, 146.
- R2: On a clock edge with `smp_valid` high, `oc_now` becomes 1 if `smp_code` is strictly greater than the selected threshold. Otherwise it becomes 0, and a sample equal to the threshold counts as no fault.
- R3: `fault_n` is always the inverse of `oc_now` and changes on the same edge.
- R4: A valid sample above the threshold sets `oc_latched` on the same edge. The bit stays set when later samples fall below the threshold.
- R5: A high `clr_req` at an edge clears `oc_latched` when the current is below the threshold. If a valid sample arrives on that edge, that sample decides. If not, the present `oc_now` decides.
- R6: A clear request has no effect while the fault persists, whether `oc_now` is 1 with no sample or an above-threshold sample arrives on the same edge.
- R7: The level register resets to code 0 (threshold 256) and loads `lvl_code` on an edge with `lvl_we` high. A sample on that same edge is judged against the old level.
- R8: During and after reset, `oc_now` is 0, `oc_latched` is 0 and `fault_n` is 1.
- R9: Without `smp_valid`, `oc_now` and `fault_n` hold their values whatever `smp_code` does.
- R10: Codes above full scale, up to 1023, are compared without wrap. At level 15, 1023 trips and 746 does not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Marks a new current sample |
| smp_code | input | 10 | Unsigned current sample code |
| lvl_we | input | 1 | Write strobe for the level register |
| lvl_code | input | 4 | Level code to load |
| clr_req | input | 1 | Request to clear the sticky status |
| oc_now | output | 1 | Non-latched overcurrent status |
| oc_latched | output | 1 | Sticky overcurrent status |
| fault_n | output | 1 | Active-low fault pin |

## Verification
A clear request and a new sample can land on the same edge. The sample's verdict then decides whether the clear succeeds. The bench drives a clear together with an above-threshold sample and expects the sticky bit to survive. It then drives a clear together with a below-threshold sample and expects the bit to drop. A level write coinciding with a sample is also provoked, and the scoreboard judges it against the old threshold.

// File: rtl/oc_fault_pkg.sv
package oc_fault_pkg;

  // trip percentage of full scale for each level code
  function automatic int unsigned level_pct(input int unsigned code);
    case (code)
      0:       return 50;
      1:       return 56;
      2:       return 63;
      3:       return 69;
      4:       return 76;
      5:       return 82;
      6:       return 88;
      7:       return 95;
      8:       return 101;
      9:       return 108;
      10:      return 114;
      11:      return 120;
      12:      return 127;
      13:      return 133;
      14:      return 140;
      default: return 146;
    endcase
  endfunction

  // rounded code value for a percentage of full scale
  function automatic int unsigned pct_to_code(input int unsigned pct,
                                              input int unsigned fs);
    return (pct * fs + 50) / 100;
  endfunction

endpackage

// File: rtl/oc_level_reg.sv
module oc_level_reg #(
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [CODE_W-1:0] din,
  output logic [CODE_W-1:0] level_q
);

  always_ff @(posedge clk) begin
    if (rst)     level_q <= '0;
    else if (we) level_q <= din;
  end

  // R7: level only moves on a write strobe
  p_level_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(level_q));

endmodule

// File: rtl/oc_level_table.sv
module oc_level_table
  import oc_fault_pkg::*;
#(
  parameter int CODE_W   = 4,
  parameter int SAMPLE_W = 10,
  parameter int FS_CODE  = 511
) (
  input  logic [CODE_W-1:0]   code,
  output logic [SAMPLE_W-1:0] thr
);

  localparam int NLVL = 1 << CODE_W;

  logic [SAMPLE_W-1:0] tbl [NLVL];

  for (genvar i = 0; i < NLVL; i++) begin : g_lvl
    localparam int unsigned TV = pct_to_code(level_pct(i), FS_CODE);
    assign tbl[i] = SAMPLE_W'(TV);
  end

  assign thr = tbl[code];

endmodule

// File: rtl/oc_cmp_stage.sv
module oc_cmp_stage #(
  parameter int SAMPLE_W = 10
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                valid,
  input  logic [SAMPLE_W-1:0] sample,
  input  logic [SAMPLE_W-1:0] thr,
  output logic                over_raw,
  output logic                oc_now,
  output logic                fault_n
);

  assign over_raw = sample > thr;

  always_ff @(posedge clk) begin
    if (rst) begin
      oc_now  <= 1'b0;
      fault_n <= 1'b1;
    end else if (valid) begin
      oc_now  <= over_raw;
      fault_n <= ~over_raw;
    end
  end

  // R9: no sample, no change
  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !valid |=> $stable(oc_now) && $stable(fault_n));

  // R3: pin is the inverse of the status
  p_pin_inverse_r3: assert property (@(posedge clk) disable iff (rst)
    oc_now != fault_n);

endmodule

// File: rtl/oc_sticky_flag.sv
module oc_sticky_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_evt,
  input  logic clr_ok,
  output logic flag
);

  always_ff @(posedge clk) begin
    if (rst)          flag <= 1'b0;
    else if (set_evt) flag <= 1'b1;
    else if (clr_ok)  flag <= 1'b0;
  end

  // R6: a set and a clear on one edge leave the flag set
  p_set_wins_r6: assert property (@(posedge clk) disable iff (rst)
    set_evt |=> flag);

endmodule

// File: rtl/oc_fault_monitor.sv
module oc_fault_monitor #(
  parameter int SAMPLE_W = 10,
  parameter int CODE_W   = 4,
  parameter int FS_CODE  = 511
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                smp_valid,
  input  logic [SAMPLE_W-1:0] smp_code,
  input  logic                lvl_we,
  input  logic [CODE_W-1:0]   lvl_code,
  input  logic                clr_req,
  output logic                oc_now,
  output logic                oc_latched,
  output logic                fault_n
);

  logic [CODE_W-1:0]   level_q;
  logic [SAMPLE_W-1:0] thr;
  logic                over_raw;
  logic                below;
  logic                set_evt;
  logic                clr_ok;

  oc_level_reg #(.CODE_W(CODE_W)) u_lvl (
    .clk(clk), .rst(rst), .we(lvl_we), .din(lvl_code), .level_q(level_q)
  );

  oc_level_table #(.CODE_W(CODE_W), .SAMPLE_W(SAMPLE_W), .FS_CODE(FS_CODE)) u_tbl (
    .code(level_q), .thr(thr)
  );

  oc_cmp_stage #(.SAMPLE_W(SAMPLE_W)) u_cmp (
    .clk(clk), .rst(rst), .valid(smp_valid), .sample(smp_code), .thr(thr),
    .over_raw(over_raw), .oc_now(oc_now), .fault_n(fault_n)
  );

  // the freshest verdict on the current decides a clear
  assign below   = smp_valid ? ~over_raw : ~oc_now;
  assign set_evt = smp_valid & over_raw;
  assign clr_ok  = clr_req & below;

  oc_sticky_flag u_lat (
    .clk(clk), .rst(rst), .set_evt(set_evt), .clr_ok(clr_ok), .flag(oc_latched)
  );

  // R4: a live fault always shows in the sticky bit
  p_now_implies_latched_r4: assert property (@(posedge clk) disable iff (rst)
    oc_now |-> oc_latched);

  // R5: the sticky bit only drops after a clear request
  p_clear_needs_req_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(oc_latched) |-> $past(clr_req));

  // R6: the sticky bit never drops while the fault is live
  p_no_clear_in_fault_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(oc_latched) |-> !oc_now);

endmodule

// File: tb/oc_fault_monitor_tb.sv
module oc_fault_monitor_tb;

  localparam int CLK_PERIOD = 10;

  typedef struct {
    bit    now;
    bit    lat;
    string tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       smp_valid = 1'b0;
  logic [9:0] smp_code = '0;
  logic       lvl_we = 1'b0;
  logic [3:0] lvl_code = '0;
  logic       clr_req = 1'b0;
  logic       oc_now, oc_latched, fault_n;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;

  exp_t q[$];

  int thr_tab [16] = '{256, 286, 322, 353, 388, 419, 450, 485,
                       516, 552, 583, 613, 649, 680, 715, 746};
  int  lvl_m = 0;
  bit  now_m = 0;
  bit  lat_m = 0;

  oc_fault_monitor u_dut (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_code(smp_code),
    .lvl_we(lvl_we), .lvl_code(lvl_code), .clr_req(clr_req),
    .oc_now(oc_now), .oc_latched(oc_latched), .fault_n(fault_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input int act, input int expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // driver: apply one cycle of stimulus and queue the expected result
  task automatic step(input bit v, input int s, input bit c,
                      input bit we, input int lv, input string tag);
    exp_t e;
    bit over;
    bit blw;
    @(negedge clk);
    smp_valid = v; smp_code = 10'(s); clr_req = c;
    lvl_we = we; lvl_code = 4'(lv);
    over = v && (s > thr_tab[lvl_m]);
    blw  = v ? !over : !now_m;
    if (v) now_m = over;
    if (over) lat_m = 1;
    else if (c && blw) lat_m = 0;
    if (we) lvl_m = lv;
    e.now = now_m; e.lat = lat_m; e.tag = tag;
    q.push_back(e);
  endtask

  // monitor: compare after each edge
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        chk({e.tag, " oc_now"}, int'(oc_now), int'(e.now));
        chk({e.tag, " oc_latched"}, int'(oc_latched), int'(e.lat));
        chk({e.tag, " fault_n R3"}, int'(fault_n), int'(!e.now));
      end
    end
  end

  // watchdog
  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8: reset state
    chk("R8 now", int'(oc_now), 0);
    chk("R8 latched", int'(oc_latched), 0);
    chk("R8 fault_n", int'(fault_n), 1);
    rst = 1'b0;

    // R7: level resets to code 0 -> threshold 256
    step(1, 256, 0, 0, 0, "R7 reset level equal");
    step(1, 257, 0, 0, 0, "R7 reset level over");
    step(1, 10,  1, 0, 0, "R5 clear with low sample");

    // R7: write level 15 on the same edge as a sample, old level applies
    step(1, 300, 0, 1, 15, "R7 same edge old level");
    step(1, 300, 0, 0, 0,  "R7 new level applied");
    step(1, 0,   1, 0, 0,  "R5 clear");

    // R10: above full scale at level 15
    step(1, 746,  0, 0, 0, "R10 at top threshold");
    step(1, 1023, 0, 0, 0, "R10 max code");
    // R9: no valid, sample wiggles, outputs hold
    step(0, 0,   0, 0, 0, "R9 hold high");
    // R6: clear while fault present, no sample
    step(0, 0,   1, 0, 0, "R6 clear no sample");
    // R6: clear with an over sample on the same edge
    step(1, 900, 1, 0, 0, "R6 clear with over sample");
    // R4: below sample, sticky stays
    step(1, 5,   0, 0, 0, "R4 sticky holds");
    step(0, 1000, 0, 0, 0, "R9 hold low");
    // R5: clear with no sample while now is 0
    step(0, 0,   1, 0, 0, "R5 clear no sample");

    // R1/R2: sweep every level around its threshold
    for (int i = 0; i < 16; i++) begin
      step(0, 0, 0, 1, i, "R1 set level");
      step(1, thr_tab[i],     0, 0, 0, "R2 equal not over");
      step(1, thr_tab[i] + 1, 0, 0, 0, "R1 one above");
      step(1, thr_tab[i] - 1, 1, 0, 0, "R5 below with clear");
    end

    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule